// File: doc/BRIEF.md
# Smart-card T=0 character transceiver

This block moves characters over the single shared data line of a contact smart card under the T=0 character protocol. It runs in one direction at a time. When the transmit enable is high it turns a byte into a serial character. When the receive enable is high it rebuilds bytes from the line. The line is open-drain. The block only ever pulls it low through `line_drive_low` and reads the resolved level back on `line_in`. It idles high when nothing pulls it down.

Each character has these parts, in line order:
- a low start bit;
- eight data bits, least significant bit first;
- an even parity bit;
- a two-bit guard period in which the sender lets go of the line.

A receiver that sees bad parity pulls the line low for the first bit of that guard period. The character then stretches by one bit. The host can switch this error pulse off. In that case a sticky flag records that an error pulse was held back.

The block counts every parity error in a counter that stops at its maximum value. Reading the counter clears it. Bit timing comes from an oversampling tick, with `OSR` ticks per bit.

Top module: `sc_t0_xcvr`

## Requirements
- R1: While transmitting, each character is a start bit, then data bits 0 to 7 in that order, then a parity bit. The parity bit makes the count of ones over data and parity even. Each bit lasts OSR ticks, and `line_drive_low` is 1 exactly while the current bit is 0. The start bit begins the cycle after the `tx_valid`/`tx_ready` handshake.
- R2: After the parity bit the transmitter drives nothing for two bit times. `tx_ready` rises again 12×OSR ticks after the handshake.
- R3: If the line is low at mid-point of the first guard bit while transmitting, the transmitter treats it as an error pulse. It then waits one extra bit, and `tx_ready` returns 13×OSR ticks after the handshake.
- R4: The receiver takes a low line in idle as a start bit and samples each bit at mid-bit. For a character with correct parity it presents the byte on `rx_data` with a one-cycle `rx_valid` pulse.
- R5: A character with a parity error raises no `rx_valid`. It sets the sticky `parity_err` flag instead, and a `status_clr` pulse clears that flag.
- R6: When `inhibit_nack` is 0, a parity error makes the receiver pull the line low for exactly OSR ticks. The pulse starts at the end of the parity bit and is followed by a two-bit guard.
- R7: When `inhibit_nack` is 1, a parity error pulls nothing low. It sets the sticky `nack_inhibited` flag instead, and a `nack_clr` pulse clears that flag.
- R8: `err_count` rises by one for every received parity error, whether the error pulse is inhibited or not. It holds at 255 rather than wrapping.
- R9: A `cnt_rd` pulse clears `err_count` to 0. If an error is counted in the same cycle, the count ends at 1.
- R10: A start bit that is high again at its mid-point is dropped. It yields no byte and no error.
- R11: With both enables high, `dir_conflict` is 1, `tx_ready` is 0, nothing is driven, and characters on the line are ignored.
- R12: After reset the block has these values:
  - `line_drive_low`, `rx_valid`, `tx_ready` and the flags are 0;
  - `err_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | Oversampling tick, OSR per bit |
| line_in | input | 1 | Resolved level of the shared line |
| line_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| inhibit_nack | input | 1 | Suppress the error pulse on bad parity |
| tx_data | input | DW | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| rx_data | output | DW | Last good received byte |
| rx_valid | output | 1 | One-cycle pulse with a good byte |
| nack_clr | input | 1 | Clears `nack_inhibited` |
| status_clr | input | 1 | Clears `parity_err` |
| cnt_rd | input | 1 | Read strobe, clears the error count |
| err_count | output | CW | Saturating parity error count |
| parity_err | output | 1 | Sticky parity error flag |
| nack_inhibited | output | 1 | Sticky flag for a held-back error pulse |
| dir_conflict | output | 1 | Both directions enabled |

## Verification
The bench plays the card and checks several edge cases, each aimed at a specific mistake.

It checks the exact cycle where `tx_ready` returns, both with and without a card error pulse. An off-by-one guard length, or a transmitter that ignores the pulse, would reopen a bit early or late.

It measures where the receiver's error pulse starts and how long it lasts. A pulse aligned to the parity mid-point, or one two bits wide, would be caught.

It drives 256 errors in a row and expects 255, so a wrapping counter would read 0. It also puts a read strobe in the same cycle as a counted error and expects 1, where a clear-wins counter would give 0.

A short start glitch and a both-directions-enabled phase check that neither a glitch nor a conflict produces bytes, errors or line activity.

// File: rtl/sc_t0_pkg.sv
// Shared state encodings for the T=0 character transceiver.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package sc_t0_pkg;
    // Transmit sequencer states
    typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GUARD} tx_state_e;
    // Receive sequencer states
    typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_NACK, RX_GUARD} rx_state_e;
    // Bit times of released line after the parity bit
    localparam int GUARD_BITS = 2;
endpackage

// File: rtl/sc_t0_tx.sv
// Transmit sequencer: serialises one character (start, DW data LSB first,
// even parity) then releases the line for the guard period, lengthened by
// one bit when the far end pulls the line low in the first guard bit.
// Assumes: tick pulses OSR times per bit; active low forces idle.
module sc_t0_tx
    import sc_t0_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          tick,
    input  logic          line_in,
    input  logic [DW-1:0] data,
    input  logic          valid,
    output logic          ready,
    output logic          drive
);
    localparam int FB    = DW + 2;
    localparam int PH_W  = $clog2(OSR);
    localparam int IDX_W = $clog2(FB + GUARD_BITS + 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(OSR - 1);
    localparam logic [PH_W-1:0]  PH_MID   = PH_W'(OSR / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_PAR  = IDX_W'(FB - 1);
    localparam logic [IDX_W-1:0] G_LAST   = IDX_W'(GUARD_BITS - 1);
    localparam logic [IDX_W-1:0] G_LASTX  = IDX_W'(GUARD_BITS);

    tx_state_e         state;
    logic [PH_W-1:0]   ph;
    logic [IDX_W-1:0]  idx;
    logic [FB-1:0]     shreg;
    logic              ext;

    // Sequencer: load on handshake, shift per bit, then timed guard
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            ph    <= '0;
            idx   <= '0;
            shreg <= '1;
            ext   <= 1'b0;
        end else if (!active) begin
            state <= TX_IDLE;
            ext   <= 1'b0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (valid) begin
                        shreg <= {^data, data, 1'b0};
                        ph    <= '0;
                        idx   <= '0;
                        state <= TX_SHIFT;
                    end
                end
                TX_SHIFT: begin
                    if (tick) begin
                        if (ph == PH_LAST) begin
                            ph    <= '0;
                            shreg <= {1'b1, shreg[FB-1:1]};
                            if (idx == IDX_PAR) begin
                                idx   <= '0;
                                ext   <= 1'b0;
                                state <= TX_GUARD;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
                TX_GUARD: begin
                    if (tick) begin
                        if (ph == PH_MID && idx == '0 && !line_in)
                            ext <= 1'b1;
                        if (ph == PH_LAST) begin
                            ph <= '0;
                            if (idx == (ext ? G_LASTX : G_LAST))
                                state <= TX_IDLE;
                            else
                                idx <= idx + 1'b1;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign ready = active && (state == TX_IDLE);
    assign drive = (state == TX_SHIFT) && !shreg[0];

    // R1: the cycle after a handshake carries the low start bit
    p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> drive);
    // R2: leaving the parity bit releases the line
    p_guard_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && state == TX_SHIFT && idx == IDX_PAR && ph == PH_LAST)
        |=> !drive);
endmodule

// File: rtl/sc_t0_rx.sv
// Receive sequencer: detects a start bit, samples DW data bits and parity
// at mid-bit, delivers good bytes, and on bad parity either pulls the line
// low for one bit or records that the pulse was inhibited. Keeps the two
// sticky flags.
// Assumes: tick pulses OSR times per bit; active low forces idle.
module sc_t0_rx
    import sc_t0_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          tick,
    input  logic          line_in,
    input  logic          inhibit,
    input  logic          perr_clr,
    input  logic          inh_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          err_pulse,
    output logic          parity_err,
    output logic          nack_inh,
    output logic          drive
);
    localparam int FB    = DW + 2;
    localparam int PH_W  = $clog2(OSR);
    localparam int IDX_W = $clog2(FB + 1);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OSR - 1);
    localparam logic [PH_W-1:0]  PH_MID  = PH_W'(OSR / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_PAR = IDX_W'(FB - 1);
    localparam logic [IDX_W-1:0] G_LAST  = IDX_W'(GUARD_BITS - 1);

    rx_state_e        state;
    logic [PH_W-1:0]  ph;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    shreg;
    logic             nack_q;

    // Sequencer: start check, mid-bit sampling, error pulse and guard wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            ph        <= '0;
            idx       <= '0;
            shreg     <= '0;
            nack_q    <= 1'b0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            err_pulse <= 1'b0;
            if (!active) begin
                state <= RX_IDLE;
            end else begin
                case (state)
                    RX_IDLE: begin
                        if (tick && !line_in) begin
                            ph    <= '0;
                            idx   <= '0;
                            state <= RX_BITS;
                        end
                    end
                    RX_BITS: begin
                        if (tick) begin
                            if (ph == PH_MID) begin
                                if (idx == '0) begin
                                    if (line_in) state <= RX_IDLE;
                                end else if (idx == IDX_PAR) begin
                                    if (^{line_in, shreg}) begin
                                        err_pulse <= 1'b1;
                                        nack_q    <= !inhibit;
                                    end else begin
                                        rx_data  <= shreg;
                                        rx_valid <= 1'b1;
                                        nack_q   <= 1'b0;
                                    end
                                end else begin
                                    shreg <= {line_in, shreg[DW-1:1]};
                                end
                            end
                            if (ph == PH_LAST) begin
                                ph <= '0;
                                if (idx == IDX_PAR) begin
                                    idx   <= '0;
                                    state <= nack_q ? RX_NACK : RX_GUARD;
                                end else begin
                                    idx <= idx + 1'b1;
                                end
                            end else begin
                                ph <= ph + 1'b1;
                            end
                        end
                    end
                    RX_NACK: begin
                        if (tick) begin
                            if (ph == PH_LAST) begin
                                ph    <= '0;
                                idx   <= '0;
                                state <= RX_GUARD;
                            end else begin
                                ph <= ph + 1'b1;
                            end
                        end
                    end
                    RX_GUARD: begin
                        if (tick) begin
                            if (ph == PH_LAST) begin
                                ph <= '0;
                                if (idx == G_LAST) state <= RX_IDLE;
                                else               idx   <= idx + 1'b1;
                            end else begin
                                ph <= ph + 1'b1;
                            end
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // Sticky flags: clear pulses first, a new error in the same cycle wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parity_err <= 1'b0;
            nack_inh   <= 1'b0;
        end else begin
            if (perr_clr) parity_err <= 1'b0;
            if (inh_clr)  nack_inh   <= 1'b0;
            if (err_pulse) begin
                parity_err <= 1'b1;
                if (!nack_q) nack_inh <= 1'b1;
            end
        end
    end

    assign drive = (state == RX_NACK);

    // R4: a delivered byte is a single-cycle pulse
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R5: an errored character is never delivered
    p_no_deliver_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !rx_valid);
    // R6: the error pulse starts only straight out of the bit sequence
    p_nack_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> $past(state) == RX_BITS);
endmodule

// File: rtl/sc_t0_errcnt.sv
// Saturating receive error counter with clear-on-read; a read and a new
// error in one cycle leave a count of one.
// Assumes: inc and rd are single-cycle strobes.
module sc_t0_errcnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          rd,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    // Counter update: read clears, error adds one below the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n)                    count <= '0;
        else if (rd)                   count <= inc ? CW'(1) : '0;
        else if (inc && count != CNT_MAX) count <= count + 1'b1;
    end

    // R8: holds at the ceiling
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !rd && count == CNT_MAX) |=> count == CNT_MAX);
    // R8: one step per error below the ceiling
    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !rd && count != CNT_MAX) |=> count == CW'($past(count) + 1'b1));
    // R9: a read with no error empties the counter
    p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !inc) |=> count == '0);
endmodule

// File: rtl/sc_t0_xcvr.sv
// Top of the T=0 character transceiver: picks the direction from the two
// enables (neither runs when both are set), merges the line drive and
// hosts the error counter.
// Assumes: line_in is the resolved open-drain level, already synchronous.
module sc_t0_xcvr #(
    parameter int OSR = 16,
    parameter int DW  = 8,
    parameter int CW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          line_in,
    output logic          line_drive_low,
    input  logic          tx_en,
    input  logic          rx_en,
    input  logic          inhibit_nack,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    input  logic          nack_clr,
    input  logic          status_clr,
    input  logic          cnt_rd,
    output logic [CW-1:0] err_count,
    output logic          parity_err,
    output logic          nack_inhibited,
    output logic          dir_conflict
);
    logic tx_active, rx_active;
    logic tx_drive, rx_drive, err_pulse;

    assign dir_conflict = tx_en && rx_en;
    assign tx_active    = tx_en && !rx_en;
    assign rx_active    = rx_en && !tx_en;

    sc_t0_tx #(.OSR(OSR), .DW(DW)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (tx_active),
        .tick    (os_tick),
        .line_in (line_in),
        .data    (tx_data),
        .valid   (tx_valid),
        .ready   (tx_ready),
        .drive   (tx_drive)
    );

    sc_t0_rx #(.OSR(OSR), .DW(DW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (rx_active),
        .tick       (os_tick),
        .line_in    (line_in),
        .inhibit    (inhibit_nack),
        .perr_clr   (status_clr),
        .inh_clr    (nack_clr),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .err_pulse  (err_pulse),
        .parity_err (parity_err),
        .nack_inh   (nack_inhibited),
        .drive      (rx_drive)
    );

    sc_t0_errcnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (err_pulse),
        .rd    (cnt_rd),
        .count (err_count)
    );

    assign line_drive_low = (tx_drive && tx_active) || (rx_drive && rx_active);

    // R11: a direction conflict never leaves the line pulled or a byte offered
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dir_conflict |-> (!line_drive_low && !tx_ready));
    // R12: the first cycle out of reset is quiet
    p_reset_quiet_r12: assert property (@(posedge clk)
        !rst_n |=> (!line_drive_low && !rx_valid && err_count == '0));
endmodule

// File: tb/sc_t0_xcvr_tb.sv
`timescale 1ns/1ps
module sc_t0_xcvr_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       card_low = 1'b0;
    logic       line;
    logic       drv;
    logic       tx_en = 1'b0, rx_en = 1'b0, inhibit_nack = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0, tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       nack_clr = 1'b0, status_clr = 1'b0, cnt_rd = 1'b0;
    logic [7:0] err_count;
    logic       parity_err, nack_inhibited, dir_conflict;

    int n_chk = 0, n_fail = 0;
    int rx_seen = 0;
    logic [7:0] rx_last = 8'h00;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    assign line = ~(drv | card_low);

    sc_t0_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .line_in(line),
        .line_drive_low(drv), .tx_en(tx_en), .rx_en(rx_en),
        .inhibit_nack(inhibit_nack), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .nack_clr(nack_clr), .status_clr(status_clr), .cnt_rd(cnt_rd),
        .err_count(err_count), .parity_err(parity_err),
        .nack_inhibited(nack_inhibited), .dir_conflict(dir_conflict)
    );

    // Byte monitor, sampled away from the active edge
    always @(negedge clk) if (rx_valid) begin
        rx_seen++;
        rx_last = rx_data;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Card sends one character; then watches the guard area for our pulse
    task automatic card_send(input logic [7:0] d, input bit flip, input bit rd_on_err,
                             output int first, output int width);
        logic [9:0] fr;
        fr = {(^d) ^ flip, d, 1'b0};
        first = -1;
        width = 0;
        for (int b = 0; b < 10; b++) begin
            card_low = ~fr[b];
            for (int t = 0; t < 16; t++) begin
                cnt_rd = rd_on_err && (b == 9) && (t == 9);
                @(negedge clk);
            end
        end
        card_low = 1'b0;
        cnt_rd = 1'b0;
        for (int k = 160; k < 224; k++) begin
            if (drv) begin
                if (first < 0) first = k;
                width++;
            end
            @(negedge clk);
        end
    endtask

    // Transmit one byte; card may pull the first guard bit low
    task automatic tx_send(input logic [7:0] d, input bit card_nack, output int ready_at);
        logic [9:0] fr;
        int bad;
        fr = {^d, d, 1'b0};
        bad = 0;
        ready_at = -1;
        tx_data = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        for (int k = 1; k < 260 && ready_at < 0; k++) begin
            card_low = card_nack && (k >= 161) && (k <= 176);
            if (k % 16 == 9 && k < 160 && drv != ~fr[(k - 9) / 16]) bad++;
            if ((k == 169 || k == 185) && drv) bad++;
            if (tx_ready) ready_at = k;
            else @(negedge clk);
        end
        card_low = 1'b0;
        check("R1/R2 bit pattern and released guard", bad, 0);
    endtask

    // {data, bad parity, inhibit}
    localparam logic [9:0] RXV [6] = '{
        {8'h00, 1'b0, 1'b0}, {8'hA5, 1'b0, 1'b0}, {8'h3C, 1'b1, 1'b0},
        {8'hFF, 1'b0, 1'b1}, {8'h81, 1'b1, 1'b1}, {8'h7E, 1'b1, 1'b0}
    };

    initial begin
        int f, w, rdy, exp_err, seen0;
        exp_err = 0;
        repeat (4) @(negedge clk);
        // R12 reset state
        check("R12 drive", int'(drv), 0);
        check("R12 count", int'(err_count), 0);
        check("R12 flags", int'(parity_err) + int'(nack_inhibited) + int'(rx_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 ready idle", int'(tx_ready), 0);

        // Transmit direction
        tx_en = 1'b1;
        @(negedge clk);
        tx_send(8'hA5, 1'b0, rdy);
        check("R2 ready return", rdy, 193);
        tx_send(8'h3C, 1'b0, rdy);
        check("R2 ready return second", rdy, 193);
        tx_send(8'h81, 1'b1, rdy);
        check("R3 extended guard", rdy, 209);
        tx_en = 1'b0;

        // Receive vector table
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            seen0 = rx_seen;
            inhibit_nack = RXV[i][0];
            card_send(RXV[i][9:2], RXV[i][1], 1'b0, f, w);
            if (RXV[i][1]) begin
                exp_err++;
                check("R5 no byte on error", rx_seen - seen0, 0);
                check("R5 parity flag", int'(parity_err), 1);
                check("R7 inhibited flag", int'(nack_inhibited), int'(RXV[i][0]));
                check("R6 pulse width", w, RXV[i][0] ? 0 : 16);
                check("R6 pulse start", f, RXV[i][0] ? -1 : 161);
            end else begin
                check("R4 byte count", rx_seen - seen0, 1);
                check("R4 byte value", int'(rx_last), int'(RXV[i][9:2]));
                check("R4 no pulse", w, 0);
            end
            check("R8 count", int'(err_count), exp_err);
            status_clr = 1'b1;
            nack_clr = 1'b1;
            @(negedge clk);
            status_clr = 1'b0;
            nack_clr = 1'b0;
            check("R5/R7 clear", int'(parity_err) + int'(nack_inhibited), 0);
        end
        inhibit_nack = 1'b0;

        // R10 short start glitch
        seen0 = rx_seen;
        card_low = 1'b1;
        repeat (4) @(negedge clk);
        card_low = 1'b0;
        repeat (40) @(negedge clk);
        check("R10 glitch no byte", rx_seen - seen0, 0);
        check("R10 glitch no error", int'(err_count), exp_err);
        card_send(8'h5A, 1'b0, 1'b0, f, w);
        check("R10 next byte", int'(rx_last), 8'h5A);

        // R11 both enables
        tx_en = 1'b1;
        @(negedge clk);
        check("R11 conflict flag", int'(dir_conflict), 1);
        check("R11 no ready", int'(tx_ready), 0);
        seen0 = rx_seen;
        card_send(8'h33, 1'b1, 1'b0, f, w);
        check("R11 no pulse", w, 0);
        check("R11 no error", int'(err_count) + int'(parity_err), exp_err);
        check("R11 no byte", rx_seen - seen0, 0);
        tx_en = 1'b0;
        repeat (4) @(negedge clk);

        // R9 plain read
        cnt_rd = 1'b1;
        @(negedge clk);
        cnt_rd = 1'b0;
        check("R9 read clears", int'(err_count), 0);

        // R8 saturation
        inhibit_nack = 1'b1;
        for (int i = 0; i < 256; i++) card_send(8'h0F, 1'b1, 1'b0, f, w);
        check("R8 saturates", int'(err_count), 255);

        // R9 read coinciding with a counted error
        card_send(8'hF0, 1'b1, 1'b1, f, w);
        check("R9 read plus error", int'(err_count), 1);
        cnt_rd = 1'b1;
        @(negedge clk);
        cnt_rd = 1'b0;
        check("R9 read after", int'(err_count), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1-run expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule